// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Controller

This block is the control front end of a pipelined synchronous SRAM whose data pins are shared between reads and writes. Every control, address and write-data input is captured on the rising clock edge. From those samples the block decides whether the cycle starts a new access, continues the current one, deselects the device or does nothing. It also works out which bytes of a word to write, and it keeps read data in an output register with its own output-enable flag. The shared data pins are modelled as a separate input bus, output bus and drive-enable.

Two address strobes can open an access. The processor strobe only counts while the first select is active. It always begins with a read, and any write it carries lands one clock later. The controller strobe writes in the same cycle it opens. Between strobes, each clock continues the open access, either at the same address or at the next address in a 2-bit linear wrap. The output-enable input is asynchronous and gates only the drive flag.

Top module: `sbs_ctl`

## Requirements
- R1: When a read is sampled at a clock edge, the word at the access address appears on `dq_out` just after that edge, and `dq_oe` is high if `oe_n` is low.
- R2: A read happens when a strobe opens an access with `wr_all_n` and `wr_byte_n` both high. When the controller strobe opens with either of them low, the cycle is a write: `dq_oe` goes low and no read data is loaded.
- R3: The processor strobe has no effect while `sel_a_n` is high. With the controller strobe high, that cycle acts as a plain continue cycle of whatever access is open.
- R4: A processor-strobe access is a read on its first clock, and all write inputs are ignored on that clock. The write inputs and `dq_in` are sampled on the second clock, which writes at the same address when `adv_n` is high.
- R5: A controller-strobe write with all selects active writes `dq_in` at `addr` on the edge where the strobe is sampled.
- R6: Bit i of `byte_sel_n` selects byte i (bits 8i+7:8i). When `wr_all_n` is low, all bytes are written whatever `byte_sel_n` holds. Otherwise, with `wr_byte_n` low, only bytes whose select bit is low are written. Unselected bytes keep their old contents, and a byte write with no byte selected changes nothing.
- R7: While the device is deselected, `dq_oe` stays low, including during the cycle in which a new access is being presented. Drive resumes only after the edge that samples the first read.
- R8: After any edge that samples a write cycle, `dq_oe` is low regardless of `oe_n`.
- R9: A strobe sampled with any select inactive (`sel_a_n` high, `sel_b` low or `sel_c_n` high) deselects the device, and `dq_oe` is low right after that edge.
- R10: `oe_n` acts without a clock. It forces `dq_oe` low while high and does not alter `dq_out`.
- R11: Back-to-back reads return one new word per clock.
- R12: In a continue cycle with `adv_n` low, the two low address bits advance by one and wrap from 3 to 0 while the upper bits hold. With `adv_n` high, the address holds.
- R13: During and right after reset, the device is deselected and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | First select, active low, also gates the processor strobe |
| sel_b | input | 1 | Second select, active high |
| sel_c_n | input | 1 | Third select, active low |
| wr_all_n | input | 1 | Global write, writes every byte, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | NB | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 8*NB | Write data from the shared bus |
| dq_out | output | 8*NB | Registered read data |
| dq_oe | output | 1 | Drive enable for the shared bus |

## Verification
The main function is tried with three kinds of pattern. The first is a table of controller-strobe writes: global writes with partial byte selects, single and paired byte writes, and a byte write with no byte selected. Reading every word back separates the override path from the masking path and from the write that does nothing. The second pattern is a processor-strobe access that carries junk write data on its first clock. Its readback shows whether the first clock was treated as a read or as a write. The third is a burst started at low bits 2, followed by advance and hold cycles, which tells the wrap from a carry into the upper bits and tells a hold from an advance.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    CK_IDLE   = 3'd0,
    CK_DESEL  = 3'd1,
    CK_NEW_RD = 3'd2,
    CK_NEW_WR = 3'd3,
    CK_RUN_RD = 3'd4,
    CK_RUN_WR = 3'd5
  } cyc_e;

  function automatic logic cyc_is_read(cyc_e k);
    return (k == CK_NEW_RD) || (k == CK_RUN_RD);
  endfunction

  function automatic logic cyc_is_write(cyc_e k);
    return (k == CK_NEW_WR) || (k == CK_RUN_WR);
  endfunction

  function automatic logic cyc_is_new(cyc_e k);
    return (k == CK_NEW_RD) || (k == CK_NEW_WR);
  endfunction

  function automatic logic cyc_is_run(cyc_e k);
    return (k == CK_RUN_RD) || (k == CK_RUN_WR);
  endfunction

  // two-bit linear wrap of the burst counter
  function automatic logic [1:0] burst_step(logic [1:0] c);
    return c + 2'd1;
  endfunction

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
(
  input  logic strb_cpu_n,
  input  logic strb_ctl_n,
  input  logic sel_a_n,
  input  logic sel_b,
  input  logic sel_c_n,
  input  logic wr_all_n,
  input  logic wr_byte_n,
  input  logic sel_q,
  output cyc_e kind,
  output logic cpu_start
);

  logic cs_ok;
  logic cpu_live;
  logic ctl_live;
  logic wr_req;

  assign cs_ok    = !sel_a_n && sel_b && !sel_c_n;
  // processor strobe counts only while the first select is active
  assign cpu_live = !strb_cpu_n && !sel_a_n;
  assign ctl_live = !strb_ctl_n && !cpu_live;
  assign wr_req   = !wr_all_n || !wr_byte_n;
  assign cpu_start = cpu_live && cs_ok;

  always_comb begin
    if (cpu_live) begin
      // write inputs ignored on the first clock of a processor access
      kind = cs_ok ? CK_NEW_RD : CK_DESEL;
    end else if (ctl_live) begin
      if (!cs_ok)      kind = CK_DESEL;
      else if (wr_req) kind = CK_NEW_WR;
      else             kind = CK_NEW_RD;
    end else if (sel_q) begin
      kind = wr_req ? CK_RUN_WR : CK_RUN_RD;
    end else begin
      kind = CK_IDLE;
    end
  end

endmodule

// File: rtl/sbs_addr.sv
module sbs_addr
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          kind,
  input  logic [AW-1:0] addr_in,
  input  logic          adv_n,
  output logic [AW-1:0] acc_addr,
  output logic          sel_q
);

  logic [AW-1:0] addr_q;

  always_comb begin
    if (cyc_is_new(kind)) begin
      acc_addr = addr_in;
    end else if (cyc_is_run(kind) && !adv_n) begin
      acc_addr = {addr_q[AW-1:2], burst_step(addr_q[1:0])};
    end else begin
      acc_addr = addr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      if (cyc_is_new(kind) || cyc_is_run(kind)) addr_q <= acc_addr;
      if (cyc_is_new(kind))     sel_q <= 1'b1;
      else if (kind == CK_DESEL) sel_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cyc_e            kind,
  input  logic [AW-1:0]   acc_addr,
  input  logic            wr_all_n,
  input  logic            wr_byte_n,
  input  logic [NB-1:0]   byte_sel_n,
  input  logic [8*NB-1:0] dq_in,
  output logic [8*NB-1:0] rd_q,
  output logic            drive_q
);

  localparam int DW    = 8 * NB;
  localparam int DEPTH = 1 << AW;

  function automatic logic [NB-1:0] lane_mask(logic all_n, logic byte_n,
                                              logic [NB-1:0] sel_n);
    if (!all_n)       return '1;
    else if (!byte_n) return ~sel_n;
    else              return '0;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [NB-1:0] wmask;

  assign wmask = lane_mask(wr_all_n, wr_byte_n, byte_sel_n);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (cyc_is_write(kind) && wmask[b])
        mem[acc_addr][8*b +: 8] <= dq_in[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= cyc_is_read(kind);
      if (cyc_is_read(kind)) rd_q <= mem[acc_addr];
    end
  end

endmodule

// File: rtl/sbs_ctl.sv
module sbs_ctl
  import sbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            strb_cpu_n,
  input  logic            strb_ctl_n,
  input  logic            adv_n,
  input  logic            sel_a_n,
  input  logic            sel_b,
  input  logic            sel_c_n,
  input  logic            wr_all_n,
  input  logic            wr_byte_n,
  input  logic [NB-1:0]   byte_sel_n,
  input  logic            oe_n,
  input  logic [8*NB-1:0] dq_in,
  output logic [8*NB-1:0] dq_out,
  output logic            dq_oe
);

  cyc_e          kind;
  logic          cpu_start;
  logic          sel_q;
  logic [AW-1:0] acc_addr;
  logic          drive_q;

  // named events for the checker
  logic ev_read;
  logic ev_write;
  logic ev_desel;
  logic ev_cpu_start;

  assign ev_read      = cyc_is_read(kind);
  assign ev_write     = cyc_is_write(kind);
  assign ev_desel     = (kind == CK_DESEL);
  assign ev_cpu_start = cpu_start;

  sbs_decode u_decode (
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .wr_all_n   (wr_all_n),
    .wr_byte_n  (wr_byte_n),
    .sel_q      (sel_q),
    .kind       (kind),
    .cpu_start  (cpu_start)
  );

  sbs_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .addr_in  (addr),
    .adv_n    (adv_n),
    .acc_addr (acc_addr),
    .sel_q    (sel_q)
  );

  sbs_array #(.AW(AW), .NB(NB)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .acc_addr   (acc_addr),
    .wr_all_n   (wr_all_n),
    .wr_byte_n  (wr_byte_n),
    .byte_sel_n (byte_sel_n),
    .dq_in      (dq_in),
    .rd_q       (dq_out),
    .drive_q    (drive_q)
  );

  // output enable is asynchronous and gates only the drive flag
  assign dq_oe = drive_q && !oe_n;

endmodule

// File: rtl/sbs_ctl_chk.sv
module sbs_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic strb_cpu_n,
  input logic strb_ctl_n,
  input logic sel_a_n,
  input logic oe_n,
  input logic dq_oe,
  input logic ev_read,
  input logic ev_write,
  input logic ev_desel,
  input logic ev_cpu_start,
  input logic sel_q
);

  p_reset_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dq_oe);

  p_read_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |=> (dq_oe || oe_n));

  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> !dq_oe);

  p_desel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desel |=> !dq_oe);

  p_cpu_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && sel_a_n && strb_ctl_n) |=> $stable(sel_q));

  p_cpu_first_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cpu_start |-> !ev_write);

endmodule

bind sbs_ctl sbs_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strb_cpu_n   (strb_cpu_n),
  .strb_ctl_n   (strb_ctl_n),
  .sel_a_n      (sel_a_n),
  .oe_n         (oe_n),
  .dq_oe        (dq_oe),
  .ev_read      (ev_read),
  .ev_write     (ev_write),
  .ev_desel     (ev_desel),
  .ev_cpu_start (ev_cpu_start),
  .sel_q        (sel_q)
);

// File: tb/sbs_ctl_tb.sv
`timescale 1ns/1ps
module sbs_ctl_tb;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 8 * NB;
  localparam int NT = 8;

  // {addr[5:0], data[31:0], byte_sel_n[3:0], global}
  localparam logic [42:0] TBL [NT] = '{
    {6'd3,  32'h11223344, 4'b1110, 1'b0},
    {6'd3,  32'hDEADBEEF, 4'b0101, 1'b0},
    {6'd5,  32'hCAFEF00D, 4'b1111, 1'b1},
    {6'd9,  32'h0BADC0DE, 4'b0000, 1'b0},
    {6'd9,  32'h77777777, 4'b1111, 1'b0},
    {6'd12, 32'h13579BDF, 4'b0011, 1'b1},
    {6'd14, 32'h2468ACE0, 4'b1011, 1'b0},
    {6'd3,  32'hFFFFFFFF, 4'b0111, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          strb_cpu_n, strb_ctl_n, adv_n;
  logic          sel_a_n, sel_b, sel_c_n;
  logic          wr_all_n, wr_byte_n;
  logic [NB-1:0] byte_sel_n;
  logic          oe_n;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_vec = 0;
  int n_bad = 0;
  logic [DW-1:0] model [1 << AW];

  always #5 clk = ~clk;

  sbs_ctl #(.AW(AW), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
    .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rest();
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_sel_n = '1;
    dq_in = '0;
  endtask

  task automatic ctl_read(logic [AW-1:0] a);
    rest();
    strb_ctl_n = 1'b0;
    addr = a;
    tick();
    rest();
  endtask

  task automatic ctl_write(logic [AW-1:0] a, logic [DW-1:0] d,
                           logic [NB-1:0] bs, logic glob);
    rest();
    strb_ctl_n = 1'b0; addr = a;
    wr_all_n = !glob; wr_byte_n = 1'b0; byte_sel_n = bs; dq_in = d;
    tick();
    check("R8 write tristate", {31'd0, dq_oe}, 32'd0);
    for (int b = 0; b < NB; b++)
      if (glob || !bs[b]) model[a][8*b +: 8] = d[8*b +: 8];
    rest();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rest();
    addr = '0; oe_n = 1'b0; rst_n = 1'b0;
    repeat (3) tick();
    check("R13 reset oe", {31'd0, dq_oe}, 32'd0);
    rst_n = 1'b1;
    tick();
    check("R13 post-reset oe", {31'd0, dq_oe}, 32'd0);

    // preload with global writes (R5, R6)
    for (int i = 0; i < 32; i++) begin
      logic [7:0] v;
      v = 8'(i);
      ctl_write(AW'(i), {8'h5A, v, ~v, v * 8'd3}, 4'b1010, 1'b1);
    end

    // table of byte and global writes (R5, R6)
    for (int t = 0; t < NT; t++)
      ctl_write(TBL[t][42:37], TBL[t][36:5], TBL[t][4:1], TBL[t][0]);

    // back-to-back readback (R1, R2, R11)
    for (int i = 0; i < 16; i++) begin
      ctl_read(AW'(i));
      check("R1 R6 R11 readback", dq_out, model[i]);
      check("R2 read drives", {31'd0, dq_oe}, 32'd1);
    end

    // R10 asynchronous output enable
    ctl_read(6'd3);
    oe_n = 1'b1; #1;
    check("R10 oe off", {31'd0, dq_oe}, 32'd0);
    check("R10 data held", dq_out, model[3]);
    oe_n = 1'b0; #1;
    check("R10 oe on", {31'd0, dq_oe}, 32'd1);

    // R3 processor strobe ignored with first select inactive
    ctl_read(6'd7);
    strb_cpu_n = 1'b0; sel_a_n = 1'b1; addr = 6'd12;
    tick();
    rest();
    check("R3 still driving", {31'd0, dq_oe}, 32'd1);
    check("R3 continued read", dq_out, model[7]);

    // R9 deselect via strobe, R7 stay off until first read sampled
    ctl_read(6'd4);
    strb_cpu_n = 1'b0; sel_c_n = 1'b1;
    tick();
    rest();
    check("R9 deselect tristate", {31'd0, dq_oe}, 32'd0);
    tick();
    check("R7 idle while deselected", {31'd0, dq_oe}, 32'd0);
    strb_ctl_n = 1'b0; addr = 6'd5; #1;
    check("R7 first cycle tristate", {31'd0, dq_oe}, 32'd0);
    tick();
    rest();
    check("R7 drive after first read", {31'd0, dq_oe}, 32'd1);
    check("R7 data", dq_out, model[5]);

    // R4 processor-strobe write: first clock is a read
    rest();
    strb_cpu_n = 1'b0; addr = 6'd20; wr_all_n = 1'b0; dq_in = 32'hBAD0BAD0;
    tick();
    check("R4 first clock reads", dq_out, model[20]);
    check("R4 first clock drives", {31'd0, dq_oe}, 32'd1);
    rest();
    wr_byte_n = 1'b0; byte_sel_n = 4'b1110; dq_in = 32'h000000C3;
    tick();
    check("R4 R8 second clock write", {31'd0, dq_oe}, 32'd0);
    model[20][7:0] = 8'hC3;
    rest();
    ctl_read(6'd20);
    check("R4 written byte only", dq_out, model[20]);

    // R12 burst: start at low bits 2, wrap, hold
    ctl_read(6'd6);
    check("R12 start", dq_out, model[6]);
    adv_n = 1'b0; tick();
    check("R12 advance", dq_out, model[7]);
    tick();
    check("R12 wrap", dq_out, model[4]);
    adv_n = 1'b1; tick();
    check("R12 hold", dq_out, model[4]);
    adv_n = 1'b0; tick();
    check("R12 advance after hold", dq_out, model[5]);
    rest();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule